// File: doc/BRIEF.md
# USB Host Controller Command and Status Unit

This unit holds the command and status state of a USB 2.0 style host controller. Software writes a command word that sets run/stop, picks the frame list size and enables the periodic and asynchronous schedules. A 32-bit status word shows these enables and the halted state as the hardware actually applies them. Each of these reported bits moves to its new value only after a parameterised number of microframe ticks. The unit also keeps a microframe index counter that advances while running.

Six sticky event flags record several events: transfer completions, transfer errors, port changes, frame index wraps, host bus errors and doorbell-requested schedule advances. Software clears a flag by writing 1 to it. A separate enable mask selects which flags drive the single interrupt output. Walking the schedules, mastering the system bus and the port logic live in other blocks, which send pulses into this unit.

Top module: `usb_hc_status`

## Requirements
- R1: After reset the command word reads 0, the status word reads 0x0000_1000 (only the halted bit set), the frame index reads 0 and `irq_o` is 0.
- R2: The command word sits at byte address 0x20, status at 0x24, interrupt enable at 0x28 and frame index at 0x2C. Other addresses read 0. Status bits 31:16 and 11:6 read 0, and status bit 13 follows `reclaim_i` in the same cycle.
- R3: Status bit 15 (asynchronous active) follows command bit 5, and status bit 14 (periodic active) follows command bit 4. Each takes the new value on the LAG_TICKS-th microframe tick after its enable differs from it, and not before.
- R4: Status bit 12 (halted) reads 0 from the cycle after run/stop (command bit 0) is written 1. After run/stop clears, bit 12 stays 0 until the LAG_TICKS-th microframe tick and then reads 1.
- R5: A `host_err_i` pulse sets status bit 4 and clears run/stop. It wins over a command write that sets run/stop in the same cycle.
- R6: Writing 1 to command bit 6 arms a doorbell, which reads back as 1. The next `async_adv_i` pulse sets status bit 5 and disarms the doorbell. An advance with no doorbell armed sets nothing.
- R7: The 14-bit frame index (read at 0x2C) goes up by one on each `uframe_tick_i` while running and wraps from 0x3FFF to 0. A write to it takes effect only while run/stop is 0.
- R8: Status bit 3 is set when a tick changes frame index bit 13, 12 or 11, for command bits 3:2 equal to 00, 01 or 10. The value 11 behaves like 00.
- R9: Status bit 2 is set in the cycle after any bit of `port_chg_i` rises. A level held high does not set it again.
- R10: A `cmpl_i` pulse with `cmpl_err_i` sets status bit 1. With `cmpl_ioc_i` it sets status bit 0. With both it sets both bits.
- R11: Writing 1 to a status bit in 5:0 clears it. Writing 0 leaves it unchanged. An event arriving in the same cycle as a clear leaves the bit set.
- R12: `irq_o` is 1 exactly when some status bit in 5:0 is set together with the matching bit of the interrupt enable word (0x28, bits 5:0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write byte address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 8 | Register read byte address |
| rd_data_o | output | 32 | Register read data (combinational) |
| uframe_tick_i | input | 1 | One pulse per microframe |
| async_adv_i | input | 1 | Asynchronous schedule advanced |
| host_err_i | input | 1 | Host bus error (parity, master or target abort) |
| port_chg_i | input | N_PORTS | Per-port change indications (level) |
| cmpl_i | input | 1 | Transaction completed |
| cmpl_err_i | input | 1 | Completed transaction ended in error |
| cmpl_ioc_i | input | 1 | Completed transaction requested an interrupt |
| reclaim_i | input | 1 | Asynchronous reclamation status |
| run_o | output | 1 | Run/stop state |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can act in the same cycle. A software W1C clear can meet a status event, and a software write that sets run/stop can meet a host bus error. The bench drives the write strobe and the event pulse on the same falling edge. It then reads back the status flag, which must still be set, and `run_o`, which must be 0. It also sweeps every list-size encoding across both toggle directions of the selected frame index bit. At each tick it compares the wrap flag and the index with values worked out from the index arithmetic.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned EVT_N  = 6;

  localparam logic [ADDR_W-1:0] CMD_OFS  = 8'h20;
  localparam logic [ADDR_W-1:0] STS_OFS  = 8'h24;
  localparam logic [ADDR_W-1:0] IEN_OFS  = 8'h28;
  localparam logic [ADDR_W-1:0] FIDX_OFS = 8'h2C;

  typedef enum logic [1:0] {
    FL_1024 = 2'b00,
    FL_512  = 2'b01,
    FL_256  = 2'b10,
    FL_RSVD = 2'b11
  } fl_size_e;

  // event flag positions in the status word
  localparam int unsigned EV_DONE = 0;
  localparam int unsigned EV_XERR = 1;
  localparam int unsigned EV_PORT = 2;
  localparam int unsigned EV_WRAP = 3;
  localparam int unsigned EV_HERR = 4;
  localparam int unsigned EV_ADV  = 5;
endpackage

// File: rtl/usbhc_lag_track.sv
module usbhc_lag_track #(
  parameter int unsigned LAG     = 3,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic tgt_i,
  output logic st_o
);
  localparam int unsigned CNT_W = (LAG > 1) ? $clog2(LAG) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LAG - 1);

  logic             st_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RST_VAL;
      cnt_q <= '0;
    end else if (st_q == tgt_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) begin
        st_q  <= tgt_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign st_o = st_q;
endmodule

// File: rtl/usbhc_frame_ctr.sv
module usbhc_frame_ctr
  import usbhc_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_val_i,
  input  logic [1:0]       size_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             wrap_o
);
  localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

  logic [IDX_W-1:0] idx_q, nxt, sel_mask;
  logic             adv;

  always_comb begin
    nxt = idx_q + ONE;
    unique case (fl_size_e'(size_i))
      FL_512:  sel_mask = ONE << (IDX_W - 2);
      FL_256:  sel_mask = ONE << (IDX_W - 3);
      default: sel_mask = ONE << (IDX_W - 1);
    endcase
  end

  assign adv    = tick_i & run_i;
  assign wrap_o = adv & (|((idx_q ^ nxt) & sel_mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (ld_i)  idx_q <= ld_val_i;
    else if (adv)   idx_q <= nxt;
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/usbhc_evt_regs.sv
module usbhc_evt_regs #(
  parameter int unsigned N = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sts_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // event beats clear
      else if (clr_i[g]) q <= 1'b0;
    end
    assign sts_o[g] = q;
  end
endmodule

// File: rtl/usb_hc_status.sv
module usb_hc_status
  import usbhc_pkg::*;
#(
  parameter int unsigned LAG_TICKS = 3,
  parameter int unsigned N_PORTS   = 4,
  parameter int unsigned IDX_W     = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  input  logic               uframe_tick_i,
  input  logic               async_adv_i,
  input  logic               host_err_i,
  input  logic [N_PORTS-1:0] port_chg_i,
  input  logic               cmpl_i,
  input  logic               cmpl_err_i,
  input  logic               cmpl_ioc_i,
  input  logic               reclaim_i,
  output logic               run_o,
  output logic               irq_o
);
  localparam int unsigned N_TRK = 3;  // 0 async, 1 periodic, 2 halted
  localparam logic [N_TRK-1:0] TRK_RST = 3'b100;

  logic               run_q, pse_q, ase_q, db_q;
  logic [1:0]         fl_q;
  logic [EVT_N-1:0]   ien_q, sts_q, evt_set, evt_clr;
  logic [N_PORTS-1:0] port_q;
  logic [N_TRK-1:0]   trk_tgt, sched_st;
  logic [IDX_W-1:0]   fidx;
  logic               wr_cmd, wr_sts, wr_ien, wr_fidx, wrap, halted;
  logic [DATA_W-1:0]  cmd_word, sts_word;

  assign wr_cmd  = wr_en_i && (wr_addr_i == CMD_OFS);
  assign wr_sts  = wr_en_i && (wr_addr_i == STS_OFS);
  assign wr_ien  = wr_en_i && (wr_addr_i == IEN_OFS);
  assign wr_fidx = wr_en_i && (wr_addr_i == FIDX_OFS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      pse_q  <= 1'b0;
      ase_q  <= 1'b0;
      fl_q   <= 2'b00;
      db_q   <= 1'b0;
      ien_q  <= '0;
      port_q <= '0;
    end else begin
      port_q <= port_chg_i;
      if (host_err_i)  run_q <= 1'b0;
      else if (wr_cmd) run_q <= wr_data_i[0];
      if (wr_cmd) begin
        fl_q  <= wr_data_i[3:2];
        pse_q <= wr_data_i[4];
        ase_q <= wr_data_i[5];
      end
      if (db_q && async_adv_i)     db_q <= 1'b0;
      if (wr_cmd && wr_data_i[6])  db_q <= 1'b1;
      if (wr_ien) ien_q <= wr_data_i[EVT_N-1:0];
    end
  end

  assign trk_tgt = {~run_q, pse_q, ase_q};

  for (genvar g = 0; g < N_TRK; g++) begin : g_trk
    usbhc_lag_track #(
      .LAG     (LAG_TICKS),
      .RST_VAL (TRK_RST[g])
    ) u_trk (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_i (uframe_tick_i),
      .tgt_i  (trk_tgt[g]),
      .st_o   (sched_st[g])
    );
  end

  usbhc_frame_ctr #(.IDX_W(IDX_W)) u_fctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (uframe_tick_i),
    .run_i    (run_q),
    .ld_i     (wr_fidx && !run_q),
    .ld_val_i (wr_data_i[IDX_W-1:0]),
    .size_i   (fl_q),
    .idx_o    (fidx),
    .wrap_o   (wrap)
  );

  always_comb begin
    evt_set          = '0;
    evt_set[EV_DONE] = cmpl_i && cmpl_ioc_i;
    evt_set[EV_XERR] = cmpl_i && cmpl_err_i;
    evt_set[EV_PORT] = |(port_chg_i & ~port_q);
    evt_set[EV_WRAP] = wrap;
    evt_set[EV_HERR] = host_err_i;
    evt_set[EV_ADV]  = db_q && async_adv_i;
    evt_clr          = wr_sts ? wr_data_i[EVT_N-1:0] : '0;
  end

  usbhc_evt_regs #(.N(EVT_N)) u_evt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (evt_set),
    .clr_i  (evt_clr),
    .sts_o  (sts_q)
  );

  // halted reads 0 whenever run/stop is set, even before the lag elapses
  assign halted   = sched_st[2] && !run_q;
  assign cmd_word = {25'b0, db_q, ase_q, pse_q, fl_q, 1'b0, run_q};
  assign sts_word = {16'b0, sched_st[0], sched_st[1], reclaim_i, halted,
                     6'b0, sts_q};

  always_comb begin
    unique case (rd_addr_i)
      CMD_OFS:  rd_data_o = cmd_word;
      STS_OFS:  rd_data_o = sts_word;
      IEN_OFS:  rd_data_o = DATA_W'(ien_q);
      FIDX_OFS: rd_data_o = DATA_W'(fidx);
      default:  rd_data_o = '0;
    endcase
  end

  assign run_o = run_q;
  assign irq_o = |(sts_q & ien_q);
endmodule

// File: rtl/usbhc_chk.sv
module usbhc_chk
  import usbhc_pkg::*;
#(
  parameter int unsigned IDX_W = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              uframe_tick_i,
  input logic              async_adv_i,
  input logic              host_err_i,
  input logic              run_o,
  input logic              irq_o,
  input logic [EVT_N-1:0]  sts_q,
  input logic [IDX_W-1:0]  fidx,
  input logic              db_q,
  input logic              async_st
);
  logic [EVT_N-1:0] clr_m;
  logic             fidx_wr;
  assign clr_m   = (wr_en_i && wr_addr_i == STS_OFS) ? wr_data_i[EVT_N-1:0] : '0;
  assign fidx_wr = wr_en_i && (wr_addr_i == FIDX_OFS);

  // R5
  host_err_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_err_i |=> !run_o);

  // R11
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sts_q & $past(sts_q & ~clr_m)) == $past(sts_q & ~clr_m)));

  // R12
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sts_q != '0));

  // R7
  fidx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!uframe_tick_i && !fidx_wr) |=> $stable(fidx));

  // R3
  async_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !uframe_tick_i |=> $stable(async_st));

  // R6
  doorbell_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_q && async_adv_i) |=> sts_q[EV_ADV]);
endmodule

bind usb_hc_status usbhc_chk #(.IDX_W(IDX_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_addr_i     (wr_addr_i),
  .wr_data_i     (wr_data_i),
  .uframe_tick_i (uframe_tick_i),
  .async_adv_i   (async_adv_i),
  .host_err_i    (host_err_i),
  .run_o         (run_o),
  .irq_o         (irq_o),
  .sts_q         (sts_q),
  .fidx          (fidx),
  .db_q          (db_q),
  .async_st      (sched_st[0])
);

// File: tb/sim_usb_hc_status.sv
module sim_usb_hc_status;
  localparam int LAG = 3;
  localparam logic [7:0] A_CMD = 8'h20, A_STS = 8'h24, A_IEN = 8'h28, A_FIX = 8'h2C;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic        tick = 1'b0, adv = 1'b0, herr = 1'b0;
  logic [3:0]  pchg = '0;
  logic        cmpl = 1'b0, cerr = 1'b0, cioc = 1'b0, recl = 1'b0;
  logic        run, irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  usb_hc_status #(.LAG_TICKS(LAG), .N_PORTS(4), .IDX_W(14)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .uframe_tick_i(tick), .async_adv_i(adv), .host_err_i(herr),
    .port_chg_i(pchg), .cmpl_i(cmpl), .cmpl_err_i(cerr), .cmpl_ioc_i(cioc),
    .reclaim_i(recl), .run_o(run), .irq_o(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pulse_cmpl(input logic e, input logic i);
    cmpl = 1'b1; cerr = e; cioc = i; @(negedge clk);
    cmpl = 1'b0; cerr = 1'b0; cioc = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_CMD, v); chk("R1 cmd", v, 32'h0);
    rd(A_STS, v); chk("R1 sts", v, 32'h0000_1000);
    rd(A_FIX, v); chk("R1 fidx", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 map, reserved and reclaim
    recl = 1'b1; rd(A_STS, v); chk("R2 reclaim", v, 32'h0000_3000);
    recl = 1'b0; rd(8'h30, v); chk("R2 unmapped", v, 32'h0);

    // R3 schedule status lag
    wr(A_CMD, 32'h20);
    rd(A_STS, v); chk("R3 async before", v, 32'h0000_1000);
    ticks(LAG - 1); rd(A_STS, v); chk("R3 async lag-1", v, 32'h0000_1000);
    ticks(1); rd(A_STS, v); chk("R3 async on", v, 32'h0000_9000);
    wr(A_CMD, 32'h10);
    ticks(LAG - 1); rd(A_STS, v); chk("R3 swap lag-1", v, 32'h0000_9000);
    ticks(1); rd(A_STS, v); chk("R3 swap done", v, 32'h0000_5000);
    wr(A_CMD, 32'h0); ticks(LAG);
    rd(A_STS, v); chk("R3 both off", v, 32'h0000_1000);

    // R4 halted tracking
    wr(A_CMD, 32'h1);
    rd(A_STS, v); chk("R4 halt clr on run", v[12], 1'b0);
    chk("R4 run_o", {31'b0, run}, 32'h1);
    ticks(LAG);
    wr(A_CMD, 32'h0);
    rd(A_STS, v); chk("R4 halt after stop", v[12], 1'b0);
    ticks(LAG - 1); rd(A_STS, v); chk("R4 halt lag-1", v[12], 1'b0);
    ticks(1); rd(A_STS, v); chk("R4 halt set", v[12], 1'b1);

    // R7 R8 frame index sweep over list sizes and both toggle directions
    for (int sz = 0; sz < 4; sz++) begin
      int sel;
      sel = (sz == 1) ? 12 : (sz == 2) ? 11 : 13;
      for (int s = 0; s < 2; s++) begin
        int m;
        m = (s == 0) ? ((1 << sel) - 3) : (((1 << (sel + 1)) - 3) & 16'h3FFF);
        wr(A_CMD, 32'(sz << 2));
        wr(A_FIX, 32'(m));
        wr(A_STS, 32'h3F);
        wr(A_CMD, 32'((sz << 2) | 1));
        for (int k = 0; k < 5; k++) begin
          int nm, ex;
          ticks(1);
          nm = (m + 1) & 16'h3FFF;
          ex = ((m ^ nm) >> sel) & 1;
          rd(A_STS, v); chk("R8 wrap flag", {31'b0, v[3]}, 32'(ex));
          rd(A_FIX, v); chk("R7 fidx step", v, 32'(nm));
          if (ex != 0) wr(A_STS, 32'h8);
          m = nm;
        end
        wr(A_FIX, 32'h123);
        rd(A_FIX, v); chk("R7 write while running ignored", v, 32'(m));
        wr(A_CMD, 32'(sz << 2));
      end
    end
    wr(A_CMD, 32'h0);
    wr(A_STS, 32'h3F);

    // R5 host error beats same-cycle run set
    wr_en = 1'b1; wr_addr = A_CMD; wr_data = 32'h1; herr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; herr = 1'b0;
    chk("R5 run stays clear", {31'b0, run}, 32'h0);
    rd(A_STS, v); chk("R5 herr flag", v[4], 1'b1);
    wr(A_CMD, 32'h1); chk("R5 run set", {31'b0, run}, 32'h1);
    herr = 1'b1; @(negedge clk); herr = 1'b0;
    chk("R5 run cleared by herr", {31'b0, run}, 32'h0);
    wr(A_STS, 32'h3F);

    // R6 doorbell
    wr(A_CMD, 32'h40);
    rd(A_CMD, v); chk("R6 doorbell armed", v[6], 1'b1);
    adv = 1'b1; @(negedge clk); adv = 1'b0;
    rd(A_STS, v); chk("R6 adv flag", v[5:0], 6'h20);
    rd(A_CMD, v); chk("R6 doorbell cleared", v[6], 1'b0);
    wr(A_STS, 32'h20);
    adv = 1'b1; @(negedge clk); adv = 1'b0;
    rd(A_STS, v); chk("R6 unarmed adv", v[5:0], 6'h00);

    // R9 port change edge
    pchg = 4'b0001; @(negedge clk); @(negedge clk);
    rd(A_STS, v); chk("R9 port rise", v[5:0], 6'h04);
    wr(A_STS, 32'h4); @(negedge clk);
    rd(A_STS, v); chk("R9 held level no reset", v[5:0], 6'h00);
    pchg = 4'b1001; @(negedge clk);
    rd(A_STS, v); chk("R9 second port rise", v[5:0], 6'h04);

    // R12 interrupt mask
    wr(A_IEN, 32'h04); chk("R12 irq enabled", {31'b0, irq}, 32'h1);
    wr(A_IEN, 32'h3B); chk("R12 irq masked", {31'b0, irq}, 32'h0);
    pchg = 4'b0000;
    wr(A_STS, 32'h3F);
    chk("R12 irq after clear", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h0);

    // R10 completion events
    pulse_cmpl(1'b1, 1'b0); rd(A_STS, v); chk("R10 err only", v[5:0], 6'h02);
    wr(A_STS, 32'h3F);
    pulse_cmpl(1'b1, 1'b1); rd(A_STS, v); chk("R10 err and ioc", v[5:0], 6'h03);
    wr(A_STS, 32'h3F);
    pulse_cmpl(1'b0, 1'b1); rd(A_STS, v); chk("R10 ioc only", v[5:0], 6'h01);
    wr(A_STS, 32'h3F);
    cerr = 1'b1; cioc = 1'b1; @(negedge clk); cerr = 1'b0; cioc = 1'b0;
    rd(A_STS, v); chk("R10 no cmpl strobe", v[5:0], 6'h00);

    // R11 write-one-to-clear and same-cycle set
    pulse_cmpl(1'b1, 1'b0);
    wr(A_STS, 32'h0); rd(A_STS, v); chk("R11 write 0 keeps", v[5:0], 6'h02);
    wr_en = 1'b1; wr_addr = A_STS; wr_data = 32'h2; cmpl = 1'b1; cerr = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; cmpl = 1'b0; cerr = 1'b0;
    rd(A_STS, v); chk("R11 set beats clear", v[5:0], 6'h02);
    wr(A_STS, 32'h2); rd(A_STS, v); chk("R11 clear", v[5:0], 6'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule